// File: doc/BRIEF.md
# Errored Second Interrupt Generator

This block gathers the alarm and error-event flags produced by a T1 receiver and keeps a sticky record of each one. Eight event classes are tracked: framing errors, CRC errors, line code violations, loss of frame alignment, loss of signal, all-ones alarm (AIS), receive slips and transmit slips. A programmable enable mask picks which of these classes count toward the errored-second condition. When any enabled class fires, the block latches an errored-second status bit.

A free-running divider on the receive line clock produces a one-second tick. Each tick latches a second status bit, which tells software to collect the alarm state and the error counters.

Software sees the block through two ports. A configuration write port loads the enable mask and the two interrupt enables. A status read port returns every latched bit and clears the latched state on the read. The interrupt output is asserted while either latched condition is present and its interrupt enable is set.

Top module: `es_irq_gen`

## Requirements
- R1: After reset, the status word is all zeros, the configuration register is all zeros and `irq_o` is low.
- R2: A high bit on `evt_i` sets the same bit of the status word in the next cycle, whatever the enable mask holds. The bit map is: 0 framing error, 1 CRC error, 2 code violation, 3 frame alignment lost, 4 signal lost, 5 AIS, 6 receive slip, 7 transmit slip.
- R3: Status bit NUM_EVT (the errored-second flag) is set in the cycle after an event arrives on a class whose enable bit `cfg_wdata_i[i]` was written as 1. Events on classes whose enable bit is 0 never set this flag.
- R4: Every status bit holds its value until a read cycle (`st_rd_i` high). A read returns the current value on `st_rdata_o` in that same cycle and clears the bit at the following edge.
- R5: When an event and a read fall in the same cycle, the event's status bit and any errored-second flag it causes are set after that edge.
- R6: Status bit NUM_EVT+1 (the one-second flag) is set once every SEC_TC receive clock cycles.
- R7: `irq_o` is high exactly when (errored-second flag AND `cfg_wdata_i[NUM_EVT]`) OR (one-second flag AND `cfg_wdata_i[NUM_EVT+1]`), using the last written configuration.
- R8: When a one-second tick and a read fall in the same cycle, the one-second flag is set after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rx_i | input | 1 | Receive line clock; also the time base for the one-second divider |
| rst_rx_ni | input | 1 | Active-low reset, synchronous to clk_rx_i |
| evt_i | input | NUM_EVT | Event flags from the receive detectors, one bit per class |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | NUM_EVT+2 | Class enables [NUM_EVT-1:0], errored-second interrupt enable [NUM_EVT], one-second interrupt enable [NUM_EVT+1] |
| st_rd_i | input | 1 | Status read strobe; clears the latched status |
| st_rdata_o | output | NUM_EVT+2 | Event bits [NUM_EVT-1:0], errored-second flag [NUM_EVT], one-second flag [NUM_EVT+1] |
| irq_o | output | 1 | Interrupt request |

## Verification
Single-class pulses on an enabled class and on a masked class show whether the mask gates only the errored-second flag and leaves the raw event record alone. A mixed multi-bit pattern and an all-ones burst with every class disabled separate a per-bit enable from a whole-word one. Reads timed to land on the same edge as an event or a one-second tick show whether a set wins over a clear. The spacing between successive one-second interrupts, with only that enable on, pins down the divider's terminal count exactly.

// File: rtl/es_irq_pkg.sv
package es_irq_pkg;

   localparam int unsigned ES_NUM_EVT = 8;

   // Bit positions of the event classes on evt_i and in the status word
   typedef enum logic [2:0] {
      EV_FRAME_ERR = 3'd0,
      EV_CRC_ERR   = 3'd1,
      EV_CODE_VIOL = 3'd2,
      EV_ALIGN_OUT = 3'd3,
      EV_SIG_LOST  = 3'd4,
      EV_AIS       = 3'd5,
      EV_RX_SLIP   = 3'd6,
      EV_TX_SLIP   = 3'd7
   } es_evt_e;

   // Helper for the derived widths of the config and status words
   function automatic int unsigned es_word_w(input int unsigned n_evt);
      return n_evt + 2;
   endfunction

endpackage

// File: rtl/es_sticky.sv
module es_sticky #(
   parameter int unsigned W = 1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] set_i,
   input  logic         clr_i,
   output logic [W-1:0] q_o
);

   if (W < 1) begin : g_bad_w
      $error("es_sticky: W must be at least 1");
   end

   // A set in the same cycle as a clear takes priority
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         q_o <= '0;
      end else begin
         q_o <= (q_o & ~{W{clr_i}}) | set_i;
      end
   end

endmodule

// File: rtl/es_sec_div.sv
module es_sec_div #(
   parameter int unsigned TC = 1544000
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic tick_o
);

   localparam int unsigned CW = (TC > 1) ? $clog2(TC) : 1;
   localparam logic [CW-1:0] LAST = CW'(TC - 1);

   if (TC < 2) begin : g_bad_tc
      $error("es_sec_div: TC must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   assign tick_o = (cnt_q == LAST);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (tick_o) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/es_irq_comb.sv
module es_irq_comb #(
   parameter bit REG_OUT = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic es_flag_i,
   input  logic es_ie_i,
   input  logic sec_flag_i,
   input  logic sec_ie_i,
   output logic irq_o
);

   logic req;

   assign req = (es_flag_i & es_ie_i) | (sec_flag_i & sec_ie_i);

   if (REG_OUT) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            irq_q <= 1'b0;
         end else begin
            irq_q <= req;
         end
      end
      assign irq_o = irq_q;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk_i ^ rst_ni;
      assign irq_o = req;
   end

endmodule

// File: rtl/es_irq_gen.sv
module es_irq_gen
   import es_irq_pkg::*;
#(
   parameter int unsigned NUM_EVT = ES_NUM_EVT,
   parameter int unsigned SEC_TC  = 1544000,
   parameter bit          IRQ_REG = 1'b0,
   localparam int unsigned WW     = es_word_w(NUM_EVT)
) (
   input  logic               clk_rx_i,
   input  logic               rst_rx_ni,
   input  logic [NUM_EVT-1:0] evt_i,
   input  logic               cfg_we_i,
   input  logic [WW-1:0]      cfg_wdata_i,
   input  logic               st_rd_i,
   output logic [WW-1:0]      st_rdata_o,
   output logic               irq_o
);

   localparam int unsigned ES_BIT  = NUM_EVT;
   localparam int unsigned SEC_BIT = NUM_EVT + 1;

   if (NUM_EVT < 1) begin : g_bad_nevt
      $error("es_irq_gen: NUM_EVT must be at least 1");
   end
   if (SEC_TC < 2) begin : g_bad_tc
      $error("es_irq_gen: SEC_TC must be at least 2");
   end

   logic [WW-1:0]      cfg_q;
   logic [NUM_EVT-1:0] evt_en;
   logic               es_ie;
   logic               sec_ie;
   logic               es_hit;
   logic               sec_tick;
   logic [NUM_EVT-1:0] evt_q;
   logic               es_q;
   logic               sec_q;

   // Configuration register: class enables and interrupt enables
   always_ff @(posedge clk_rx_i) begin
      if (!rst_rx_ni) begin
         cfg_q <= '0;
      end else if (cfg_we_i) begin
         cfg_q <= cfg_wdata_i;
      end
   end

   assign evt_en = cfg_q[NUM_EVT-1:0];
   assign es_ie  = cfg_q[ES_BIT];
   assign sec_ie = cfg_q[SEC_BIT];
   assign es_hit = |(evt_i & evt_en);

   // Raw event record, unmasked
   es_sticky #(.W(NUM_EVT)) u_evt_st (
      .clk_i  (clk_rx_i),
      .rst_ni (rst_rx_ni),
      .set_i  (evt_i),
      .clr_i  (st_rd_i),
      .q_o    (evt_q)
   );

   // Errored-second flag
   es_sticky #(.W(1)) u_es_st (
      .clk_i  (clk_rx_i),
      .rst_ni (rst_rx_ni),
      .set_i  (es_hit),
      .clr_i  (st_rd_i),
      .q_o    (es_q)
   );

   es_sec_div #(.TC(SEC_TC)) u_div (
      .clk_i  (clk_rx_i),
      .rst_ni (rst_rx_ni),
      .tick_o (sec_tick)
   );

   // One-second flag
   es_sticky #(.W(1)) u_sec_st (
      .clk_i  (clk_rx_i),
      .rst_ni (rst_rx_ni),
      .set_i  (sec_tick),
      .clr_i  (st_rd_i),
      .q_o    (sec_q)
   );

   es_irq_comb #(.REG_OUT(IRQ_REG)) u_irq (
      .clk_i      (clk_rx_i),
      .rst_ni     (rst_rx_ni),
      .es_flag_i  (es_q),
      .es_ie_i    (es_ie),
      .sec_flag_i (sec_q),
      .sec_ie_i   (sec_ie),
      .irq_o      (irq_o)
   );

   assign st_rdata_o = {sec_q, es_q, evt_q};

endmodule

// File: rtl/es_irq_chk.sv
module es_irq_chk #(
   parameter int unsigned NUM_EVT = 8,
   parameter int unsigned SEC_TC  = 1544000,
   parameter bit          IRQ_REG = 1'b0
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_EVT-1:0] evt,
   input logic               st_rd,
   input logic [NUM_EVT+1:0] st_rdata,
   input logic [NUM_EVT+1:0] cfg,
   input logic               irq
);

   localparam int unsigned CW = (SEC_TC > 1) ? $clog2(SEC_TC) : 1;
   localparam logic [CW-1:0] LAST = CW'(SEC_TC - 1);

   // Independent one-second phase model
   logic [CW-1:0] ref_cnt;
   always_ff @(posedge clk) begin
      if (!rst_n) ref_cnt <= '0;
      else if (ref_cnt == LAST) ref_cnt <= '0;
      else ref_cnt <= ref_cnt + 1'b1;
   end

   AST_RESET_QUIET: assert property (@(posedge clk)
      $rose(rst_n) |-> (st_rdata == '0 && cfg == '0 && !irq)); // R1

   AST_EVT_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((st_rdata[NUM_EVT-1:0] & $past(evt)) == $past(evt))); // R2

   AST_ES_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_rdata[NUM_EVT]) |-> $past((evt & cfg[NUM_EVT-1:0]) != '0)); // R3

   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !st_rd |=> (($past(st_rdata) & ~st_rdata) == '0)); // R4

   AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (st_rd && ((evt & cfg[NUM_EVT-1:0]) != '0)) |=> st_rdata[NUM_EVT]); // R5

   AST_SEC_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_cnt == LAST) |=> st_rdata[NUM_EVT+1]); // R6

   AST_SEC_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_rdata[NUM_EVT+1]) |-> $past(ref_cnt == LAST)); // R6

   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (!IRQ_REG && irq) |-> (st_rdata[NUM_EVT+1:NUM_EVT] != 2'b00)); // R7

   AST_IRQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (!IRQ_REG && cfg[NUM_EVT+1:NUM_EVT] == 2'b00) |-> !irq); // R7

   AST_TICK_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (st_rd && ref_cnt == LAST) |=> st_rdata[NUM_EVT+1]); // R8

endmodule

bind es_irq_gen es_irq_chk #(
   .NUM_EVT (NUM_EVT),
   .SEC_TC  (SEC_TC),
   .IRQ_REG (IRQ_REG)
) u_chk (
   .clk      (clk_rx_i),
   .rst_n    (rst_rx_ni),
   .evt      (evt_i),
   .st_rd    (st_rd_i),
   .st_rdata (st_rdata_o),
   .cfg      (cfg_q),
   .irq      (irq_o)
);

// File: tb/es_irq_gen_tb.sv
module es_irq_gen_tb;

   localparam int unsigned NE = 8;
   localparam int unsigned WW = NE + 2;
   localparam int unsigned TC = 40;
   localparam logic [WW-1:0] M_NOSEC = {1'b0, {(WW-1){1'b1}}};
   localparam logic [WW-1:0] M_SEC   = {1'b1, {(WW-1){1'b0}}};
   localparam logic [WW-1:0] ES      = WW'(1) << NE;
   localparam logic [WW-1:0] SEC     = WW'(1) << (NE + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NE-1:0] evt = '0;
   logic          cfg_we = 1'b0;
   logic [WW-1:0] cfg_wd = '0;
   logic          st_rd = 1'b0;
   logic [WW-1:0] st_rdata;
   logic          irq;

   int n_chk = 0;
   int n_fail = 0;
   int pcnt = 0;
   bit done = 1'b0;

   typedef struct {
      logic [WW-1:0] exp;
      logic [WW-1:0] msk;
      string         tag;
   } sb_item_t;
   sb_item_t sbq[$];

   always #2 clk = ~clk;
   always @(posedge clk) pcnt <= pcnt + 1;

   es_irq_gen #(.NUM_EVT(NE), .SEC_TC(TC), .IRQ_REG(1'b0)) u_dut (
      .clk_rx_i    (clk),
      .rst_rx_ni   (rst_n),
      .evt_i       (evt),
      .cfg_we_i    (cfg_we),
      .cfg_wdata_i (cfg_wd),
      .st_rd_i     (st_rd),
      .st_rdata_o  (st_rdata),
      .irq_o       (irq)
   );

   // Monitor: compares every read against the next expected item
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (st_rd) begin
            n_chk++;
            if (sbq.size() == 0) begin
               n_fail++;
               $display("FAIL %s: read with no expected item, actual %h", "scoreboard", st_rdata);
            end else begin
               sb_item_t it;
               it = sbq.pop_front();
               if ((st_rdata & it.msk) !== (it.exp & it.msk)) begin
                  n_fail++;
                  $display("FAIL %s: status actual %h expected %h (mask %h)",
                           it.tag, st_rdata & it.msk, it.exp & it.msk, it.msk);
               end
            end
         end
      end
   end

   // All tasks start and end on a falling edge
   task automatic do_read(input logic [WW-1:0] exp, input logic [WW-1:0] msk, input string tag);
      sb_item_t it;
      it.exp = exp; it.msk = msk; it.tag = tag;
      sbq.push_back(it);
      st_rd = 1'b1;
      @(negedge clk);
      st_rd = 1'b0;
   endtask

   task automatic do_cfg(input logic [WW-1:0] v);
      cfg_we = 1'b1; cfg_wd = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic pulse(input logic [NE-1:0] v);
      evt = v;
      @(negedge clk);
      evt = '0;
   endtask

   task automatic chk_irq(input logic exp, input string tag);
      n_chk++;
      if (irq !== exp) begin
         n_fail++;
         $display("FAIL %s: irq actual %b expected %b", tag, irq, exp);
      end
   endtask

   task automatic wait_irq(output int at);
      int g = 0;
      while (!irq && g < 4 * TC) begin
         @(negedge clk);
         g++;
      end
      at = pcnt;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #800000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      int n1, n2;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk_irq(1'b0, "R1");
      do_read('0, {WW{1'b1}}, "R1");

      // enables on classes 0,2,4,6 ; errored-second interrupt on
      do_cfg(ES | WW'(8'h55));
      pulse(8'h02);
      chk_irq(1'b0, "R3");
      do_read(WW'(8'h02), M_NOSEC, "R2");

      pulse(8'h04);
      chk_irq(1'b1, "R7");
      do_read(ES | WW'(8'h04), M_NOSEC, "R3");
      chk_irq(1'b0, "R4");
      do_read('0, M_NOSEC, "R4");

      // sticky hold over several idle cycles
      pulse(8'h80);
      repeat (5) @(negedge clk);
      do_read(WW'(8'h80), M_NOSEC, "R4");

      // event lands on the read cycle
      evt = 8'h10;
      do_read('0, M_NOSEC, "R5");
      evt = '0;
      do_read(ES | WW'(8'h10), M_NOSEC, "R5");

      // mixed pattern, two enabled classes among it
      pulse(8'hA5);
      do_read(ES | WW'(8'hA5), M_NOSEC, "R2");

      // every class disabled
      do_cfg(ES);
      pulse(8'hFF);
      chk_irq(1'b0, "R3");
      do_read(WW'(8'hFF), M_NOSEC, "R3");

      // flag set but its interrupt enable off
      do_cfg(WW'(8'hFF));
      pulse(8'h01);
      chk_irq(1'b0, "R7");
      do_read(ES | WW'(8'h01), M_NOSEC, "R7");

      // one-second tick only
      do_cfg(SEC);
      do_read('0, '0, "R6");
      wait_irq(n1);
      do_read(SEC, M_SEC, "R6");
      wait_irq(n2);
      n_chk++;
      if (n2 - n1 != int'(TC)) begin
         n_fail++;
         $display("FAIL R6: tick spacing actual %0d expected %0d", n2 - n1, TC);
      end
      do_read(SEC, M_SEC, "R6");
      while (pcnt != n2 + int'(TC) - 1) @(negedge clk);
      do_read('0, M_SEC, "R8");
      do_read(SEC, M_SEC, "R8");

      repeat (2) @(negedge clk);
      done = 1'b1;
      finish_run();
   end

endmodule